// File: doc/BRIEF.md
# Row-Stationary Convolution Processing Element

This block is one processing element of a spatial convolution array. Each run computes a single one-dimensional convolution primitive. A row of filter weights is loaded once into a local register file and stays there. A row of input feature-map pixels then slides past the weights. For every output position the element multiplies and accumulates one tap per cycle. It adds the partial sum that arrives from a neighbouring element and forwards the total toward the next element. A column of these elements therefore sums several primitive rows into one output row, and no partial sum is written back to a buffer.

Filter words, pixel words and incoming partial sums each arrive on their own valid/ready channel. The outgoing partial sum leaves on a fourth channel. A start pulse latches the filter length, the pixel row length and the stride. Words are 16-bit two's complement. The accumulator keeps full product precision and saturates only when the result returns to 16 bits. A fully-connected layer is the case where the filter length equals the row length. A pooling-style sum uses the same sequence.

The controller is a state machine with these states:
- `S_IDLE`: waits for a start with a legal configuration, then moves to `S_LDFLT`.
- `S_LDFLT`: takes filter words. After the last weight it moves to `S_FILL`.
- `S_FILL`: takes the first window of pixels. When the window is full it moves to `S_MAC`.
- `S_MAC`: performs one tap per cycle. After the last tap it moves to `S_ADDPS`.
- `S_ADDPS`: waits for the incoming partial sum, then moves to `S_EMIT`.
- `S_EMIT`: offers the outgoing sum. Once it is taken, the next state is `S_SLIDE` if another full window fits in the row. Otherwise it is `S_DONE` if the row is used up, or `S_DRAIN` if leftover pixels remain.
- `S_SLIDE`: takes `stride` new pixels, then returns to `S_MAC`.
- `S_DRAIN`: takes the remaining pixels, then moves to `S_DONE`.
- `S_DONE`: lasts one cycle and returns to `S_IDLE`.

Top module: `rs_conv_pe`

## Requirements
- R1: While reset is held and just after it, `busy`, `done`, `flt_ready`, `ifm_ready`, `pin_ready` and `pout_valid` are all 0.
- R2: A start is acted on only when the configuration is legal: 1 <= filter length <= FMAX, filter length <= row length <= IMAX, and 1 <= stride <= SMAX. A start with any other configuration leaves `busy` and every ready at 0.
- R3: A run takes exactly filter-length filter words. `flt_ready` is high only during that phase and is never high together with `ifm_ready`, `pin_ready` or `pout_valid`.
- R4: Output j equals sat16(sum over k of W[k]*I[j*stride+k] + P[j]), where W, I and P are signed 16-bit values and P[j] is the j-th incoming partial sum.
- R5: A run yields floor((row length - filter length)/stride)+1 outputs. It consumes one incoming partial sum per output, in arrival order.
- R6: A run consumes exactly row-length pixel words, including trailing pixels that do not complete a window. After the run `ifm_ready` stays 0.
- R7: A total above 32767 is output as 32767 (0x7FFF). A total below -32768 is output as -32768 (0x8000).
- R8: While `pout_valid` is 1 and `pout_ready` is 0, `pout_valid` stays 1 and `pout_data` is unchanged. Gaps on any input channel do not change the results.
- R9: `done` is 1 for exactly one cycle after the final output handoff and any trailing pixels. After that cycle `busy` is 0 and a new start is accepted.
- R10: When the filter length equals the row length (the fully-connected case), exactly one output is produced.
- R11: When the stride exceeds the filter length, the skipped pixels are consumed but never reach a product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Start pulse that latches the configuration |
| cfg_flen | input | $clog2(FMAX+1) | Filter row length |
| cfg_ilen | input | $clog2(IMAX+1) | Pixel row length |
| cfg_stride | input | $clog2(SMAX+1) | Window step |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run flag |
| flt_valid | input | 1 | Filter word valid |
| flt_ready | output | 1 | Filter word accepted |
| flt_data | input | DW | Filter weight |
| ifm_valid | input | 1 | Pixel word valid |
| ifm_ready | output | 1 | Pixel word accepted |
| ifm_data | input | DW | Pixel |
| pin_valid | input | 1 | Incoming partial sum valid |
| pin_ready | output | 1 | Incoming partial sum accepted |
| pin_data | input | DW | Incoming partial sum |
| pout_valid | output | 1 | Outgoing partial sum valid |
| pout_ready | input | 1 | Downstream accepts the outgoing sum |
| pout_data | output | DW | Outgoing partial sum |

## Verification
A wrong tap index, a window offset error or a missed accumulator clear shows up as a wrong value on the first affected output word, a few cycles after its window is filled. A miscounted slide or drain shifts every later window. It also leaves the pixel stream out of step, so the run either hangs waiting for pixels or leaves `ifm_ready` high after `done`. Distinct incoming partial sums per position expose any reordering on the first swapped output. Saturation errors show up only at extreme operands, and dedicated runs drive both rails.

// File: rtl/rs_pe_pkg.sv
package rs_pe_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LDFLT,
        S_FILL,
        S_MAC,
        S_ADDPS,
        S_EMIT,
        S_SLIDE,
        S_DRAIN,
        S_DONE
    } pe_state_t;

endpackage

// File: rtl/rs_pe_filt_rf.sv
module rs_pe_filt_rf #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] taps [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_tap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                taps[g] <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                taps[g] <= wr_data;
            end
        end
    end

    assign rd_data = taps[rd_idx];

endmodule

// File: rtl/rs_pe_win.sv
module rs_pe_win #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);

    // Newest pixel enters at the top entry; older pixels move toward entry 0.
    logic [DW-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        if (g == DEPTH - 1) begin : g_top
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cells[g] <= '0;
                end else if (push) begin
                    cells[g] <= din;
                end
            end
        end else begin : g_mid
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cells[g] <= '0;
                end else if (push) begin
                    cells[g] <= cells[g+1];
                end
            end
        end
    end

    assign rd_data = cells[rd_idx];

endmodule

// File: rtl/rs_pe_mac.sv
module rs_pe_mac #(
    parameter int DW   = 16,
    parameter int TAPS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tap_en,
    input  logic          tap_first,
    input  logic [DW-1:0] tap_w,
    input  logic [DW-1:0] tap_x,
    input  logic          psum_en,
    input  logic [DW-1:0] psum_in,
    output logic [DW-1:0] result
);

    localparam int ACCW = 2*DW + $clog2(TAPS) + 1;
    localparam logic signed [ACCW-1:0] MAXV = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [ACCW-1:0] MINV = {{(ACCW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [2*DW-1:0] prod;
    logic signed [ACCW-1:0] prod_x;
    logic signed [ACCW-1:0] psum_x;
    logic signed [ACCW-1:0] acc_q;
    logic signed [ACCW-1:0] total;
    logic        [DW-1:0]   sat_val;

    assign prod   = $signed(tap_w) * $signed(tap_x);
    assign prod_x = {{(ACCW-2*DW){prod[2*DW-1]}}, prod};
    assign psum_x = {{(ACCW-DW){psum_in[DW-1]}}, psum_in};
    assign total  = acc_q + psum_x;

    always_comb begin
        if (total > MAXV) begin
            sat_val = MAXV[DW-1:0];
        end else if (total < MINV) begin
            sat_val = MINV[DW-1:0];
        end else begin
            sat_val = total[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (tap_en) begin
            acc_q <= tap_first ? prod_x : (acc_q + prod_x);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (psum_en) begin
            result <= sat_val;
        end
    end

    AST_TAP_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_en && !tap_first) |-> $past(tap_en)); // R4

endmodule

// File: rtl/rs_conv_pe.sv
module rs_conv_pe
    import rs_pe_pkg::*;
#(
    parameter int DW   = 16,
    parameter int FMAX = 8,
    parameter int IMAX = 64,
    parameter int SMAX = 4,
    localparam int FLW = $clog2(FMAX + 1),
    localparam int ILW = $clog2(IMAX + 1),
    localparam int SW  = $clog2(SMAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_start,
    input  logic [FLW-1:0] cfg_flen,
    input  logic [ILW-1:0] cfg_ilen,
    input  logic [SW-1:0]  cfg_stride,
    output logic           busy,
    output logic           done,
    input  logic           flt_valid,
    output logic           flt_ready,
    input  logic [DW-1:0]  flt_data,
    input  logic           ifm_valid,
    output logic           ifm_ready,
    input  logic [DW-1:0]  ifm_data,
    input  logic           pin_valid,
    output logic           pin_ready,
    input  logic [DW-1:0]  pin_data,
    output logic           pout_valid,
    input  logic           pout_ready,
    output logic [DW-1:0]  pout_data
);

    localparam int IW = $clog2(FMAX);
    localparam logic [ILW-1:0] ONE = ILW'(1);

    pe_state_t state_q, state_d;

    logic [ILW-1:0] flen_q, ilen_q, str_q;
    logic [ILW-1:0] fcnt, wcnt, kidx, icnt;

    logic [ILW-1:0] cf_flen, cf_str;
    logic           cfg_ok, launch;
    logic           flt_fire, ifm_fire, pin_fire, pout_fire;
    logic           flt_last, fill_last, tap_last, slide_last, drain_last;
    logic           room, row_used;
    logic [ILW-1:0] wsum;
    logic [DW-1:0]  w_tap, x_tap;

    // ---------------- configuration check ----------------
    assign cf_flen = ILW'(cfg_flen);
    assign cf_str  = ILW'(cfg_stride);
    assign cfg_ok  = (cf_flen != '0) && (cfg_flen <= FLW'(FMAX))
                  && (cf_str != '0) && (cfg_stride <= SW'(SMAX))
                  && (cfg_ilen >= cf_flen) && (cfg_ilen <= ILW'(IMAX));
    assign launch  = (state_q == S_IDLE) && cfg_start && cfg_ok;

    // ---------------- handshakes and phase ends ----------------
    assign flt_fire   = flt_valid && flt_ready;
    assign ifm_fire   = ifm_valid && ifm_ready;
    assign pin_fire   = pin_valid && pin_ready;
    assign pout_fire  = pout_valid && pout_ready;

    assign flt_last   = (fcnt + ONE) == flen_q;
    assign fill_last  = (wcnt + ONE) == flen_q;
    assign tap_last   = (kidx + ONE) == flen_q;
    assign slide_last = (wcnt + ONE) == str_q;
    assign drain_last = (icnt + ONE) == ilen_q;
    assign room       = ({1'b0, icnt} + {1'b0, str_q}) <= {1'b0, ilen_q};
    assign row_used   = (icnt == ilen_q);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (launch)                   state_d = S_LDFLT;
            S_LDFLT: if (flt_fire && flt_last)     state_d = S_FILL;
            S_FILL:  if (ifm_fire && fill_last)    state_d = S_MAC;
            S_MAC:   if (tap_last)                 state_d = S_ADDPS;
            S_ADDPS: if (pin_fire)                 state_d = S_EMIT;
            S_EMIT: begin
                if (pout_fire) begin
                    if (room)          state_d = S_SLIDE;
                    else if (row_used) state_d = S_DONE;
                    else               state_d = S_DRAIN;
                end
            end
            S_SLIDE: if (ifm_fire && slide_last)   state_d = S_MAC;
            S_DRAIN: if (ifm_fire && drain_last)   state_d = S_DONE;
            S_DONE:                                state_d = S_IDLE;
            default:                               state_d = S_IDLE;
        endcase
    end

    // ---------------- state outputs ----------------
    always_comb begin
        flt_ready  = 1'b0;
        ifm_ready  = 1'b0;
        pin_ready  = 1'b0;
        pout_valid = 1'b0;
        done       = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            S_IDLE:  busy       = 1'b0;
            S_LDFLT: flt_ready  = 1'b1;
            S_FILL:  ifm_ready  = 1'b1;
            S_MAC:   ;
            S_ADDPS: pin_ready  = 1'b1;
            S_EMIT:  pout_valid = 1'b1;
            S_SLIDE: ifm_ready  = 1'b1;
            S_DRAIN: ifm_ready  = 1'b1;
            S_DONE:  done       = 1'b1;
            default: busy       = 1'b0;
        endcase
    end

    // ---------------- counters and latched configuration ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flen_q <= '0;
            ilen_q <= '0;
            str_q  <= '0;
            fcnt   <= '0;
            wcnt   <= '0;
            kidx   <= '0;
            icnt   <= '0;
        end else if (launch) begin
            flen_q <= cf_flen;
            ilen_q <= cfg_ilen;
            str_q  <= cf_str;
            fcnt   <= '0;
            wcnt   <= '0;
            kidx   <= '0;
            icnt   <= '0;
        end else begin
            if (flt_fire) begin
                fcnt <= fcnt + ONE;
            end
            if (ifm_fire) begin
                icnt <= icnt + ONE;
            end
            if (ifm_fire && (state_q == S_FILL)) begin
                wcnt <= fill_last ? '0 : (wcnt + ONE);
            end
            if (ifm_fire && (state_q == S_SLIDE)) begin
                wcnt <= slide_last ? '0 : (wcnt + ONE);
            end
            if (state_q == S_MAC) begin
                kidx <= tap_last ? '0 : (kidx + ONE);
            end
        end
    end

    // ---------------- datapath ----------------
    // The window occupies the top flen_q cells; tap k sits at FMAX-flen_q+k.
    assign wsum = ILW'(FMAX) - flen_q + kidx;

    rs_pe_filt_rf #(.DW(DW), .DEPTH(FMAX)) i_filt_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (flt_fire),
        .wr_idx  (IW'(fcnt)),
        .wr_data (flt_data),
        .rd_idx  (IW'(kidx)),
        .rd_data (w_tap)
    );

    rs_pe_win #(.DW(DW), .DEPTH(FMAX)) i_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (ifm_fire),
        .din     (ifm_data),
        .rd_idx  (IW'(wsum)),
        .rd_data (x_tap)
    );

    rs_pe_mac #(.DW(DW), .TAPS(FMAX)) i_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .tap_en    (state_q == S_MAC),
        .tap_first (kidx == '0),
        .tap_w     (w_tap),
        .tap_x     (x_tap),
        .psum_en   (pin_fire),
        .psum_in   (pin_data),
        .result    (pout_data)
    );

    // ---------------- assertions ----------------
    AST_POUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pout_valid && !pout_ready) |=> (pout_valid && $stable(pout_data))); // R8
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flt_ready, ifm_ready, pin_ready, pout_valid})); // R3
    AST_FLT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        flt_fire |-> (fcnt < flen_q)); // R3
    AST_IFM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ifm_fire |-> (icnt < ilen_q)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(flt_ready || ifm_ready || pin_ready || pout_valid)); // R2

endmodule

// File: tb/test_rs_conv_pe.sv
module test_rs_conv_pe;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_start = 1'b0;
    logic [3:0]  cfg_flen = '0;
    logic [6:0]  cfg_ilen = '0;
    logic [2:0]  cfg_stride = '0;
    logic        busy, done;
    logic        flt_valid = 1'b0, flt_ready;
    logic [15:0] flt_data = '0;
    logic        ifm_valid = 1'b0, ifm_ready;
    logic [15:0] ifm_data = '0;
    logic        pin_valid = 1'b0, pin_ready;
    logic [15:0] pin_data = '0;
    logic        pout_valid, pout_ready = 1'b0;
    logic [15:0] pout_data;

    int total = 0;
    int bad   = 0;

    logic signed [15:0] W [8];
    logic signed [15:0] I [64];
    logic signed [15:0] P [64];
    logic signed [15:0] G [64];

    always #2 clk = ~clk;

    rs_conv_pe i_rs_conv_pe (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_flen(cfg_flen),
        .cfg_ilen(cfg_ilen), .cfg_stride(cfg_stride), .busy(busy), .done(done),
        .flt_valid(flt_valid), .flt_ready(flt_ready), .flt_data(flt_data),
        .ifm_valid(ifm_valid), .ifm_ready(ifm_ready), .ifm_data(ifm_data),
        .pin_valid(pin_valid), .pin_ready(pin_ready), .pin_data(pin_data),
        .pout_valid(pout_valid), .pout_ready(pout_ready), .pout_data(pout_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill_data(input int seed);
        for (int k = 0; k < 8; k++)  W[k] = 16'(((k + seed) * 37) % 61 - 30);
        for (int i = 0; i < 64; i++) I[i] = 16'(((i * 13 + seed * 7) % 97) - 48);
        for (int j = 0; j < 64; j++) P[j] = 16'(j * 100 - seed);
    endtask

    function automatic longint ref_out(input int j, input int fl, input int st);
        longint s = 0;
        for (int k = 0; k < fl; k++) s += longint'(W[k]) * longint'(I[j*st+k]);
        s += longint'(P[j]);
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    task automatic drive_flt(input int fl, input int gap);
        for (int k = 0; k < fl; k++) begin
            flt_valid = 1'b1; flt_data = W[k];
            while (!flt_ready) @(negedge clk);
            @(negedge clk);
            flt_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
        chk(flt_ready == 1'b0, "R3 flt_ready after load", flt_ready, 0);
    endtask

    task automatic drive_ifm(input int il, input int gap);
        for (int i = 0; i < il; i++) begin
            ifm_valid = 1'b1; ifm_data = I[i];
            while (!ifm_ready) @(negedge clk);
            @(negedge clk);
            ifm_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic drive_pin(input int n, input int gap);
        for (int j = 0; j < n; j++) begin
            pin_valid = 1'b1; pin_data = P[j];
            while (!pin_ready) @(negedge clk);
            @(negedge clk);
            pin_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic collect(input int n, input bit bp, input string req);
        int got = 0;
        int cyc = 0;
        bit seen = 0;
        while (got < n) begin
            pout_ready = bp ? (cyc % 3 == 2) : 1'b1;
            cyc++;
            if (pout_valid && pout_ready) begin
                G[got] = pout_data;
                got++;
            end
            @(negedge clk);
        end
        pout_ready = 1'b0;
        for (int t = 0; t < 300 && !seen; t++) begin
            if (done) seen = 1;
            else @(negedge clk);
        end
        chk(seen, "R9 done raised", seen, 1);
        @(negedge clk);
        chk(!done && !busy, "R9 done one cycle then idle", {done, busy}, 0);
        chk(!pout_valid, {req, " no extra output"}, pout_valid, 0);
    endtask

    task automatic run_job(input int fl, input int il, input int st, input int gap,
                           input bit bp, input string req);
        int n = (il - fl) / st + 1;
        @(negedge clk);
        cfg_flen = 4'(fl); cfg_ilen = 7'(il); cfg_stride = 3'(st); cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        chk(busy == 1'b1, "R2 busy after legal start", busy, 1);
        fork
            drive_flt(fl, gap);
            drive_ifm(il, gap);
            drive_pin(n, gap);
            collect(n, bp, req);
        join
        for (int j = 0; j < n; j++)
            chk(longint'(G[j]) == ref_out(j, fl, st), req, longint'(G[j]), ref_out(j, fl, st));
        ifm_valid = 1'b1;
        for (int t = 0; t < 3; t++) begin
            chk(ifm_ready == 1'b0, "R6 no pixel taken after run", ifm_ready, 0);
            @(negedge clk);
        end
        ifm_valid = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk({busy, done, flt_ready, ifm_ready, pin_ready, pout_valid} == 6'b0,
            "R1 in reset", {busy, done, flt_ready, ifm_ready, pin_ready, pout_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, flt_ready, ifm_ready, pin_ready, pout_valid} == 6'b0,
            "R1 after reset", {busy, done, flt_ready, ifm_ready, pin_ready, pout_valid}, 0);
    endtask

    task automatic t_bad_start(input int fl, input int il, input int st);
        @(negedge clk);
        cfg_flen = 4'(fl); cfg_ilen = 7'(il); cfg_stride = 3'(st); cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        for (int t = 0; t < 3; t++) begin
            chk(!busy && !flt_ready, "R2 illegal start ignored", {busy, flt_ready}, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_saturate;
        fill_data(5);
        for (int k = 0; k < 8; k++) W[k] = 16'sh7FFF;
        for (int i = 0; i < 64; i++) I[i] = 16'sh7FFF;
        run_job(4, 6, 1, 0, 0, "R7 high rail");
        chk(G[0] == 16'sh7FFF, "R7 clamp 0x7FFF", G[0], 32767);
        for (int k = 0; k < 8; k++) W[k] = -16'sd32768;
        run_job(8, 8, 1, 0, 0, "R7 low rail");
        chk(G[0] == 16'sh8000, "R7 clamp 0x8000", G[0], -32768);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        fill_data(1);
        run_job(3, 8, 1, 0, 0, "R4 basic stride 1");
        fill_data(2);
        run_job(3, 8, 2, 0, 0, "R5 stride 2 trailing pixel");
        fill_data(3);
        run_job(2, 9, 3, 0, 0, "R11 stride beyond filter");
        fill_data(4);
        run_job(8, 8, 1, 0, 0, "R10 fully connected");
        t_saturate();
        fill_data(6);
        run_job(5, 20, 2, 2, 1, "R8 stalls and backpressure");
        t_bad_start(0, 8, 1);
        t_bad_start(5, 3, 1);
        t_bad_start(3, 8, 0);
        fill_data(7);
        run_job(1, 4, 1, 0, 0, "R9 restart after illegal starts");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule